// File: doc/BRIEF.md
# ADC Start-Event Conversion Sequencer

This block sits between the start sources of a multi-channel ADC and the converter's serial engine. It merges three kinds of start event: a one-cycle software pulse, a periodic tick from a programmable divider of the base clock, and the rising edge of an external trigger input. It turns each accepted event into conversion requests, and each request names a channel and the 3-bit gain code for that channel.

In single mode, an event yields one request, and the channel pointer steps through the configured sequence. In scan mode, an event yields a burst of requests covering channel 0 through the configured last channel. A second divisor sets the spacing between the requests of a burst. Each request also carries a tag word of channel, gain and an end-of-scan bit. The tag can be packed next to the two's-complement sample when the result returns.

Requests leave on a valid/ready stream. Once `req_valid` is high, it stays high and `req_chan`, `req_gain` and `req_tag` hold still until a cycle with `req_ready` high. A new request may load in the same cycle that the previous one is accepted. While the downstream stalls, a scan waits: the next channel goes out only after both its spacing interval has elapsed and the output slot is free. The configuration pins are plain levels, and the block treats them as quasi-static.

Top module: `adc_start_seq`

## Requirements
- R1: After reset, `req_valid` and `overrun` are 0, and the channel pointer is at channel 0.
- R2: With `cfg_per_en` high, a start event occurs every `cfg_start_div` clock cycles. A divisor of 0 or 1 gives a start event on every cycle.
- R3: With `cfg_ext_en` high, a 0-to-1 transition of `ext_trig` gives exactly one start event. Holding `ext_trig` high gives no further events.
- R4: A one-cycle pulse on `sw_start` is a start event.
- R5: In single mode, each accepted start event issues one request for the pointer channel. The pointer then steps by one, and after `cfg_last` it returns to 0.
- R6: In scan mode, one accepted start event issues requests for channels 0, 1, … `cfg_last` in ascending order. After that, nothing is issued until the next start event.
- R7: Within a scan, with `req_ready` held high, consecutive requests are issued `cfg_scan_div` cycles apart. A divisor of 0 or 1 gives back-to-back cycles.
- R8: Scan mode is taken as single mode when `cfg_seq` is 00 or `cfg_last` is 0. When `cfg_seq` is 00, every request is for channel 0.
- R9: `req_gain` for channel c is bits [2:0] of nibble c of the 64-bit word {`cfg_gain_hi`,`cfg_gain_lo`}. Nibble c occupies bits 4c+3..4c. Bit 3 of each nibble is ignored.
- R10: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and the payload stays unchanged. A stalled scan resumes in order when the slot frees.
- R11: A start event that arrives while a scan is running, or while a request is stalled, is dropped and sets `overrun`. `overrun` stays set until reset.
- R12: `req_tag` is laid out as [2:0] gain, [6:3] channel, and [7] end-of-scan. Bit 7 is 1 only on the last request of a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | External trigger level; its rising edge is a start event |
| cfg_per_en | input | 1 | Enables the periodic start divider |
| cfg_ext_en | input | 1 | Enables the external trigger |
| cfg_scan | input | 1 | 1 selects scan mode, 0 selects single mode |
| cfg_seq | input | 2 | Sequencing mode; 00 is non-sequenced |
| cfg_last | input | LAST_W | Index of the last channel in the sequence |
| cfg_start_div | input | DIV_W | Periodic start divisor |
| cfg_scan_div | input | DIV_W | Divisor for spacing within a scan |
| cfg_gain_lo | input | 32 | Gain nibbles for channels 0–7 |
| cfg_gain_hi | input | 32 | Gain nibbles for channels 8–15 |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_chan | output | 4 | Requested channel |
| req_gain | output | 3 | Gain code of the requested channel |
| req_tag | output | 8 | Result tag: end-of-scan, channel, gain |
| overrun | output | 1 | Sticky flag for a dropped start event |

## Verification
The bench builds the block with DIV_W = 8 and LAST_W = 4. The narrower divisor keeps the periodic and in-scan intervals short. The wider last-channel field lets a single scan run past channel 7, so the gain nibbles of the upper word are exercised as well as the lower one. Small divisors of 0, 1, 3, 4 and 5 cover both the every-cycle case and real spacing. A stalled ready line is used to show that pacing and overrun interact with back-pressure.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_CH = 16;
  localparam int NIB_W  = 4;
  localparam int GAIN_W = 3;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int TAG_W  = 1 + CH_W + GAIN_W;

  typedef struct packed {
    logic              eos;
    logic [CH_W-1:0]   chan;
    logic [GAIN_W-1:0] gain;
  } req_tag_t;

  // Gain code of channel ch: low bits of its nibble, the top nibble bit unused.
  function automatic logic [GAIN_W-1:0] pick_gain(
    input logic [NUM_CH*NIB_W-1:0] words,
    input logic [CH_W-1:0]         ch
  );
    return words[ch*NIB_W +: GAIN_W];
  endfunction
endpackage

// File: rtl/adc_rate_div.sv
module adc_rate_div #(
  parameter int W        = 16,
  parameter bit FREE_RUN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;

  assign lim  = (div <= W'(1)) ? '0 : div - W'(1);
  assign tick = en && (cnt >= lim);

  generate
    if (FREE_RUN) begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (clr || !en || tick) cnt <= '0;
        else                        cnt <= cnt + W'(1);
      end
      assert_wrap_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick) |=> (cnt == '0));
    end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr || !en) cnt <= '0;
        else if (!tick)      cnt <= cnt + W'(1);
      end
      assert_due_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !clr) |=> (!en || tick || !$stable(div)));
    end
  endgenerate
endmodule

// File: rtl/adc_start_src.sv
module adc_start_src #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             ext_trig,
  input  logic             per_en,
  input  logic             ext_en,
  input  logic [DIV_W-1:0] start_div,
  output logic             start_evt
);
  logic per_tick;
  logic ext_q;
  logic ext_evt;

  adc_rate_div #(.W(DIV_W), .FREE_RUN(1'b1)) u_per_div (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (per_en),
    .clr  (1'b0),
    .div  (start_div),
    .tick (per_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_trig;
  end

  assign ext_evt   = ext_en && ext_trig && !ext_q;
  assign start_evt = sw_start || per_tick || ext_evt;

  assert_ext_level_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_trig && $past(ext_trig) && !sw_start && !per_tick) |-> !start_evt);
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int LAST_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_evt,
  input  logic                    cfg_scan,
  input  logic [1:0]              cfg_seq,
  input  logic [LAST_W-1:0]       cfg_last,
  input  logic [NUM_CH*NIB_W-1:0] gain_words,
  input  logic                    scan_tick,
  input  logic                    req_ready,
  output logic                    req_valid,
  output logic [CH_W-1:0]         req_chan,
  output logic [GAIN_W-1:0]       req_gain,
  output logic [TAG_W-1:0]        req_tag,
  output logic                    overrun,
  output logic                    scan_active,
  output logic                    issue
);
  logic [CH_W-1:0] ptr;
  logic [CH_W-1:0] last_ext;
  logic [CH_W-1:0] issue_ch;
  logic            scan_eff, slot_free, busy, start_ok, scan_next, at_last, eos;
  req_tag_t        tag_q;

  assign last_ext  = CH_W'(cfg_last);
  assign scan_eff  = cfg_scan && (cfg_seq != 2'b00) && (cfg_last != '0);
  assign slot_free = !req_valid || req_ready;
  assign busy      = scan_active || !slot_free;
  assign start_ok  = start_evt && !busy;
  assign scan_next = scan_active && scan_tick && slot_free;
  assign issue     = start_ok || scan_next;
  assign at_last   = (ptr >= last_ext);
  assign eos       = scan_next && at_last;

  always_comb begin
    if (start_ok && (scan_eff || cfg_seq == 2'b00)) issue_ch = '0;
    else                                            issue_ch = ptr;
  end

  // Channel pointer and scan state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr         <= '0;
      scan_active <= 1'b0;
    end else if (start_ok && scan_eff) begin
      ptr         <= CH_W'(1);
      scan_active <= 1'b1;
    end else if (start_ok) begin
      ptr <= (cfg_seq == 2'b00 || at_last) ? '0 : ptr + CH_W'(1);
    end else if (scan_next) begin
      if (at_last) begin
        ptr         <= '0;
        scan_active <= 1'b0;
      end else begin
        ptr <= ptr + CH_W'(1);
      end
    end
  end

  // Output request register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      tag_q     <= '0;
    end else if (issue) begin
      req_valid  <= 1'b1;
      tag_q.eos  <= eos;
      tag_q.chan <= issue_ch;
      tag_q.gain <= pick_gain(gain_words, issue_ch);
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 overrun <= 1'b0;
    else if (start_evt && busy) overrun <= 1'b1;
  end

  assign req_chan = tag_q.chan;
  assign req_gain = tag_q.gain;
  assign req_tag  = tag_q;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_chan) && $stable(req_gain) && $stable(req_tag)));
  assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_busy_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && busy) |=> overrun);
  assert_scan_opens_ch0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_active) |-> (req_valid && req_chan == '0));
  assert_nonseq_ch0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cfg_seq == 2'b00) |=> (req_chan == '0));
  assert_forced_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && (cfg_seq == 2'b00 || cfg_last == '0)) |=> !scan_active);
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adc_seq_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int LAST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_start,
  input  logic              ext_trig,
  input  logic              cfg_per_en,
  input  logic              cfg_ext_en,
  input  logic              cfg_scan,
  input  logic [1:0]        cfg_seq,
  input  logic [LAST_W-1:0] cfg_last,
  input  logic [DIV_W-1:0]  cfg_start_div,
  input  logic [DIV_W-1:0]  cfg_scan_div,
  input  logic [31:0]       cfg_gain_lo,
  input  logic [31:0]       cfg_gain_hi,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CH_W-1:0]   req_chan,
  output logic [GAIN_W-1:0] req_gain,
  output logic [TAG_W-1:0]  req_tag,
  output logic              overrun
);
  logic start_evt, scan_tick, scan_active, issue;

  adc_start_src #(.DIV_W(DIV_W)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_start (sw_start),
    .ext_trig (ext_trig),
    .per_en   (cfg_per_en),
    .ext_en   (cfg_ext_en),
    .start_div(cfg_start_div),
    .start_evt(start_evt)
  );

  adc_rate_div #(.W(DIV_W), .FREE_RUN(1'b0)) u_scan_div (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (scan_active),
    .clr  (issue),
    .div  (cfg_scan_div),
    .tick (scan_tick)
  );

  adc_seq_core #(.LAST_W(LAST_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .cfg_scan   (cfg_scan),
    .cfg_seq    (cfg_seq),
    .cfg_last   (cfg_last),
    .gain_words ({cfg_gain_hi, cfg_gain_lo}),
    .scan_tick  (scan_tick),
    .req_ready  (req_ready),
    .req_valid  (req_valid),
    .req_chan   (req_chan),
    .req_gain   (req_gain),
    .req_tag    (req_tag),
    .overrun    (overrun),
    .scan_active(scan_active),
    .issue      (issue)
  );
endmodule

// File: tb/adc_start_seq_tb.sv
module adc_start_seq_tb;
  localparam int CLK_NS = 10;
  localparam int DIV_W  = 8;
  localparam int LAST_W = 4;
  localparam logic [31:0] G_LO = 32'h8F3A_C519;
  localparam logic [31:0] G_HI = 32'h6E27_B4D0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_start = 0, ext_trig = 0, cfg_per_en = 0, cfg_ext_en = 0, cfg_scan = 0;
  logic [1:0] cfg_seq = 2'b01;
  logic [LAST_W-1:0] cfg_last = '0;
  logic [DIV_W-1:0] cfg_start_div = '0, cfg_scan_div = '0;
  logic req_valid, req_ready = 1'b1, overrun;
  logic [3:0] req_chan;
  logic [2:0] req_gain;
  logic [7:0] req_tag;

  int n_chk = 0, n_fail = 0, cyc = 0, n_log = 0;
  int lg_ch[512], lg_gain[512], lg_tag[512], lg_cyc[512];

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_start_seq #(.DIV_W(DIV_W), .LAST_W(LAST_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .ext_trig(ext_trig),
    .cfg_per_en(cfg_per_en), .cfg_ext_en(cfg_ext_en), .cfg_scan(cfg_scan),
    .cfg_seq(cfg_seq), .cfg_last(cfg_last), .cfg_start_div(cfg_start_div),
    .cfg_scan_div(cfg_scan_div), .cfg_gain_lo(G_LO), .cfg_gain_hi(G_HI),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_gain(req_gain), .req_tag(req_tag), .overrun(overrun)
  );

  // Handshakes seen mid-cycle complete at the following rising edge.
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && n_log < 512) begin
      lg_ch[n_log] = req_chan; lg_gain[n_log] = req_gain;
      lg_tag[n_log] = req_tag; lg_cyc[n_log] = cyc;
      n_log = n_log + 1;
    end
  end

  function automatic int exp_gain(input int ch);
    logic [63:0] w;
    w = {G_HI, G_LO};
    return int'(w[ch*4 +: 3]);
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic chk_entry(input int i, input int ch, input int eos, input string r);
    chk(lg_ch[i] == ch, r, lg_ch[i], ch);
    chk(lg_gain[i] == exp_gain(ch), {r, "/R9 gain"}, lg_gain[i], exp_gain(ch));
    chk(lg_tag[i] == ((eos << 7) | (ch << 3) | exp_gain(ch)), {r, "/R12 tag"},
        lg_tag[i], (eos << 7) | (ch << 3) | exp_gain(ch));
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulse_sw();
    step(); sw_start = 1'b1; step(); sw_start = 1'b0;
  endtask

  task automatic do_reset();
    step(); rst_n = 1'b0;
    sw_start = 0; ext_trig = 0; cfg_per_en = 0; cfg_ext_en = 0; cfg_scan = 0;
    cfg_seq = 2'b01; cfg_last = '0; cfg_start_div = '0; cfg_scan_div = '0; req_ready = 1;
    step(3); rst_n = 1'b1; step();
  endtask

  task automatic t_reset_r1();
    int b;
    do_reset();
    b = n_log;
    chk(req_valid == 1'b0, "R1 valid after reset", req_valid, 0);
    chk(overrun == 1'b0, "R1 overrun after reset", overrun, 0);
    step(5);
    chk(n_log == b, "R1 idle issues nothing", n_log - b, 0);
  endtask

  task automatic t_single_r5();
    int b;
    do_reset();
    cfg_last = 4'd2;
    b = n_log;
    repeat (5) begin pulse_sw(); step(2); end
    chk(n_log - b == 5, "R4 one request per software pulse", n_log - b, 5);
    chk_entry(b + 0, 0, 0, "R5 single ch"); chk_entry(b + 1, 1, 0, "R5 single ch");
    chk_entry(b + 2, 2, 0, "R5 single ch"); chk_entry(b + 3, 0, 0, "R5 wrap to ch0");
    chk_entry(b + 4, 1, 0, "R5 single ch");
  endtask

  task automatic t_scan_r6();
    int b;
    do_reset();
    cfg_scan = 1; cfg_last = 4'd3; cfg_scan_div = 8'd3;
    b = n_log;
    pulse_sw(); step(30);
    chk(n_log - b == 4, "R6 scan count, nothing after last", n_log - b, 4);
    for (int i = 0; i < 4; i++) chk_entry(b + i, i, (i == 3) ? 1 : 0, "R6 scan order");
    for (int i = 1; i < 4; i++)
      chk(lg_cyc[b+i] - lg_cyc[b+i-1] == 3, "R7 in-scan spacing 3", lg_cyc[b+i] - lg_cyc[b+i-1], 3);
  endtask

  task automatic t_scan_fast_r7();
    int b;
    do_reset();
    cfg_scan = 1; cfg_last = 4'd9; cfg_scan_div = 8'd0;
    b = n_log;
    pulse_sw(); step(20);
    chk(n_log - b == 10, "R7 fast scan count", n_log - b, 10);
    for (int i = 0; i < 10; i++) chk_entry(b + i, i, (i == 9) ? 1 : 0, "R7 fast scan ch");
    for (int i = 1; i < 10; i++)
      chk(lg_cyc[b+i] - lg_cyc[b+i-1] == 1, "R7 divisor 0 back-to-back", lg_cyc[b+i] - lg_cyc[b+i-1], 1);
  endtask

  task automatic t_force_r8();
    int b;
    do_reset();
    cfg_scan = 1; cfg_last = 4'd0;
    b = n_log;
    pulse_sw(); step(4); pulse_sw(); step(4);
    chk(n_log - b == 2, "R8 last=0 gives single", n_log - b, 2);
    chk_entry(b, 0, 0, "R8 last=0 ch"); chk_entry(b + 1, 0, 0, "R8 last=0 ch");
    cfg_seq = 2'b00; cfg_last = 4'd5;
    b = n_log;
    repeat (3) begin pulse_sw(); step(4); end
    chk(n_log - b == 3, "R8 non-sequenced gives single", n_log - b, 3);
    for (int i = 0; i < 3; i++) chk_entry(b + i, 0, 0, "R8 non-sequenced ch0");
  endtask

  task automatic t_backpressure_r10();
    int b;
    do_reset();
    cfg_scan = 1; cfg_last = 4'd2; cfg_scan_div = 8'd1; req_ready = 0;
    b = n_log;
    pulse_sw(); step(1);
    repeat (5) begin
      step();
      chk(req_valid == 1'b1, "R10 valid held under stall", req_valid, 1);
      chk(req_chan == 4'd0, "R10 channel held under stall", req_chan, 0);
    end
    req_ready = 1; step(8);
    chk(n_log - b == 3, "R10 stalled scan completes", n_log - b, 3);
    for (int i = 0; i < 3; i++) chk_entry(b + i, i, (i == 2) ? 1 : 0, "R10 order after stall");
  endtask

  task automatic t_overrun_r11();
    int b;
    do_reset();
    cfg_last = 4'd3; req_ready = 0;
    b = n_log;
    pulse_sw(); step(2);
    chk(overrun == 1'b0, "R11 no overrun yet", overrun, 0);
    pulse_sw(); step(1);
    chk(overrun == 1'b1, "R11 start during stall", overrun, 1);
    req_ready = 1; step(4);
    chk(n_log - b == 1, "R11 stalled start dropped", n_log - b, 1);
    chk_entry(b, 0, 0, "R11 kept request");
    do_reset();
    cfg_scan = 1; cfg_last = 4'd3; cfg_scan_div = 8'd4;
    b = n_log;
    pulse_sw(); step(2); pulse_sw(); step(30);
    chk(overrun == 1'b1, "R11 start during scan", overrun, 1);
    chk(n_log - b == 4, "R11 scan not restarted", n_log - b, 4);
    step(5);
    chk(overrun == 1'b1, "R11 overrun sticky", overrun, 1);
  endtask

  task automatic t_periodic_r2();
    int b;
    do_reset();
    cfg_last = 4'd7; cfg_start_div = 8'd5;
    b = n_log;
    cfg_per_en = 1; step(32); cfg_per_en = 0; step(3);
    chk(n_log - b >= 5, "R2 periodic starts occur", n_log - b, 6);
    for (int i = 1; i < 5; i++)
      chk(lg_cyc[b+i] - lg_cyc[b+i-1] == 5, "R2 periodic spacing 5", lg_cyc[b+i] - lg_cyc[b+i-1], 5);
    for (int i = 0; i < 5; i++) chk_entry(b + i, i, 0, "R5 periodic single ch");
    do_reset();
    cfg_last = 4'd7; cfg_start_div = 8'd1;
    b = n_log;
    cfg_per_en = 1; step(6); cfg_per_en = 0; step(3);
    chk(n_log - b == 6, "R2 divisor 1 every cycle", n_log - b, 6);
  endtask

  task automatic t_ext_r3();
    int b;
    do_reset();
    cfg_last = 4'd7; cfg_ext_en = 1;
    b = n_log;
    step(); ext_trig = 1; step(10);
    chk(n_log - b == 1, "R3 one event per rising edge", n_log - b, 1);
    ext_trig = 0; step(3); ext_trig = 1; step(5);
    chk(n_log - b == 2, "R3 second rising edge", n_log - b, 2);
    chk_entry(b + 1, 1, 0, "R3 second edge ch");
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_fail++;
    $display("FAIL watchdog R1-all: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_single_r5();
    t_scan_r6();
    t_scan_fast_r7();
    t_force_r8();
    t_backpressure_r10();
    t_overrun_r11();
    t_periodic_r2();
    t_ext_r3();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule